// File: doc/BRIEF.md
# Two-Level Nanocoded Control Sequencer

This block is the control unit of a microprogrammed machine. A micro-address register walks a narrow micro-store. Each micro-store entry is one of two kinds. A sequencing word picks the next micro-address: an unconditional jump, a jump on a selected condition flag, or a dispatch on an external opcode. An emit word points into a wide nano-store. The nano-store entry it selects is expanded into a broad vector of parallel control lines.

Many micro-steps assert the same set of control lines. Those steps can all point at one nano-store entry, so the wide storage is spent once per distinct pattern rather than once per step. Both stores can be rewritten at run time through a load port, so a faulty control program can be corrected in the field.

After reset the sequencer is idle. A `start` pulse sets it running from the current micro-address. It then runs without stopping until the next reset.

Top module: `nano_seq`

## Requirements
- R1: While `rst` is high, `ctrl` is all zeros. On the first edge with `rst` high, `upc` becomes 0 and the sequencer becomes idle.
- R2: While idle, `upc` holds and `ctrl` is all zeros. A `start` pulse while idle makes the sequencer run from the current `upc`, which is 0 after reset.
- R3: A micro-word with bit 16 clear is an emit word. The next `upc` is `upc`+1, and address 1023 wraps to 0.
- R4: During an emit word, `ctrl` is the expansion of the nano-store entry at word bits 8:0, in the same cycle. `ctrl[51:0]` copies nano bits 51:0. For each k in 0..3, the 4-bit code v = nano[52+4k+3 : 52+4k] sets only line `ctrl[52+16k+v]` within the group `ctrl[52+16k +: 16]`.
- R5: During a sequencing word (bit 16 set), `ctrl` is all zeros.
- R6: A sequencing word whose select field (bits 15:12) is 0 loads `upc` with bits 9:0.
- R7: A sequencing word with select s in 1..14 loads `upc` with bits 9:0 if `flags[s-1]` is 1. Otherwise it loads `upc`+1. Flags that are not selected have no effect.
- R8: A sequencing word with select 15 loads `upc` with (bits 9:0 + `opcode`) modulo 1024.
- R9: A load-port write (`ld_nano`=1: nano entry `ld_addr[8:0]` gets `ld_data`; `ld_nano`=0: micro entry `ld_addr` gets `ld_data[16:0]`) takes effect at the clock edge. In the same cycle, both `ctrl` and the next-address choice still use the old contents.
- R10: Micro-words that point at the same nano entry produce identical `ctrl`. Rewriting that one nano entry changes the output of all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin running when idle |
| opcode | input | 4 | Dispatch operand for select-15 words |
| flags | input | 14 | Condition flags for selects 1..14 |
| ld_en | input | 1 | Store write enable |
| ld_nano | input | 1 | 1 writes the nano-store, 0 writes the micro-store |
| ld_addr | input | 10 | Store write address |
| ld_data | input | 68 | Store write data |
| ctrl | output | 116 | Expanded control lines |
| upc | output | 10 | Current micro-address |

## Verification
`ctrl` is a combinational function of the current `upc` and the store contents, so it is due in the same cycle as the address it belongs to. A new `upc` is due one edge after the micro-word that chose it, and a store write is visible one edge after `ld_en`. The bench keeps its own copy of every store entry it writes and a reference micro-address. It changes inputs and compares both outputs on the falling edge. For the same-cycle rule of load writes, it re-reads `ctrl` 1 ns after driving a write, before the rising edge that commits it.

// File: rtl/nano_seq.sv
module nano_seq #(
  parameter int UA_W  = 10,
  parameter int NP_W  = 9,
  parameter int MW    = 17,
  parameter int NW    = 68,
  parameter int SEL_W = 4,
  parameter int OPC_W = 4,
  parameter int FLD_N = 4,
  parameter int FLD_W = 4,
  localparam int NFLAG = 2**SEL_W - 2,
  localparam int FV    = 2**FLD_W,
  localparam int DIR_W = NW - FLD_N*FLD_W,
  localparam int CW    = DIR_W + FLD_N*FV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  input  logic [NFLAG-1:0] flags,
  input  logic             ld_en,
  input  logic             ld_nano,
  input  logic [UA_W-1:0]  ld_addr,
  input  logic [NW-1:0]    ld_data,
  output logic [CW-1:0]    ctrl,
  output logic [UA_W-1:0]  upc
);
  localparam int UDEPTH = 2**UA_W;
  localparam int NDEPTH = 2**NP_W;
  localparam logic [SEL_W-1:0] SEL_ALWAYS = '0;
  localparam logic [SEL_W-1:0] SEL_DISP   = '1;

  logic [MW-1:0] ustore [UDEPTH];
  logic [NW-1:0] nstore [NDEPTH];
  logic [UA_W-1:0] upc_q, upc_nxt;
  logic run_q;

  wire [MW-1:0]     uword   = ustore[upc_q];
  wire              is_jmp  = uword[MW-1];
  wire [SEL_W-1:0]  csel    = uword[MW-2 -: SEL_W];
  wire [UA_W-1:0]   tgt     = uword[UA_W-1:0];
  wire [NP_W-1:0]   nptr    = uword[NP_W-1:0];
  wire              unused_spare = ^uword[MW-2-SEL_W:UA_W];
  wire [NW-1:0]     nword   = nstore[nptr];
  wire [2**SEL_W-1:0] fpad  = {1'b0, flags, 1'b0};
  wire              flag_hit = fpad[csel];
  wire [UA_W-1:0]   upc_inc  = upc_q + 1'b1;
  wire [UA_W-1:0]   disp_tgt = tgt + UA_W'(opcode);

  always_comb begin
    if (!is_jmp)                 upc_nxt = upc_inc;
    else if (csel == SEL_ALWAYS) upc_nxt = tgt;
    else if (csel == SEL_DISP)   upc_nxt = disp_tgt;
    else                         upc_nxt = flag_hit ? tgt : upc_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q <= '0;
      run_q <= 1'b0;
    end else if (!run_q) begin
      if (start) run_q <= 1'b1;
    end else begin
      upc_q <= upc_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      if (ld_nano) nstore[ld_addr[NP_W-1:0]] <= ld_data;
      else         ustore[ld_addr] <= ld_data[MW-1:0];
    end
  end

  wire [CW-1:0] dec;
  assign dec[DIR_W-1:0] = nword[DIR_W-1:0];
  for (genvar f = 0; f < FLD_N; f++) begin : g_fld
    wire [FLD_W-1:0] code = nword[DIR_W + f*FLD_W +: FLD_W];
    assign dec[DIR_W + f*FV +: FV] = FV'(1) << code;
  end

  assign ctrl = (run_q && !rst && !is_jmp) ? dec : '0;
  assign upc  = upc_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (upc_q == '0 && !run_q)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> $stable(upc_q)); // R2
  AST_EMIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q && !is_jmp) |=> upc_q == UA_W'($past(upc_q) + 1'b1)); // R3
  AST_JMP_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (run_q && is_jmp && csel == SEL_ALWAYS) |=> upc_q == $past(tgt)); // R6
  AST_FLAG_MISS: assert property (@(posedge clk) disable iff (rst)
    (run_q && is_jmp && csel != SEL_ALWAYS && csel != SEL_DISP && !fpad[csel])
    |=> upc_q == UA_W'($past(upc_q) + 1'b1)); // R7
  AST_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    (run_q && is_jmp && csel == SEL_DISP)
    |=> upc_q == UA_W'($past(tgt) + $past(opcode))); // R8
endmodule

// File: tb/sim_nano_seq.sv
`timescale 1ns/1ps
module sim_nano_seq;
  localparam int CW = 116;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst = 1, start = 0, ld_en = 0, ld_nano = 0;
  logic [3:0]  opcode = 0;
  logic [13:0] flags = 0;
  logic [9:0]  ld_addr = 0;
  logic [67:0] ld_data = 0;
  wire  [CW-1:0] ctrl;
  wire  [9:0]    upc;

  nano_seq u0 (.clk(clk), .rst(rst), .start(start), .opcode(opcode), .flags(flags),
               .ld_en(ld_en), .ld_nano(ld_nano), .ld_addr(ld_addr), .ld_data(ld_data),
               .ctrl(ctrl), .upc(upc));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [16:0] us [1024];
  logic [67:0] ns [512];
  logic [9:0] m_upc = 0;
  bit m_run = 0;
  int pass = 0;
  string last = "R1";
  bit pn = 0, pm = 0;

  task automatic chk(string req, string what, logic [127:0] got, logic [127:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [CW-1:0] dcd(logic [67:0] n);
    logic [CW-1:0] r = '0;
    r[51:0] = n[51:0];
    for (int k = 0; k < 4; k++) r[52 + 16*k + int'(n[52+4*k +: 4])] = 1'b1;
    return r;
  endfunction

  function automatic logic [67:0] npat(int i, int s);
    logic [63:0] m = 64'(i) * 64'd2654435761 + 64'(s) * 64'd97;
    return {4'(i), 4'(i >> 4), 4'(i + s), 4'((i >> 2) ^ s), m[51:0]};
  endfunction

  function automatic logic [16:0] ujmp(int sel, int t);
    return {1'b1, 4'(sel), 2'b00, 10'(t)};
  endfunction

  function automatic logic [16:0] unano(int p);
    return {1'b0, 7'b0, 9'(p)};
  endfunction

  function automatic logic [9:0] nxt(logic [16:0] w, logic [9:0] u, logic [13:0] fl,
                                     logic [3:0] op, output string k);
    int sel = int'(w[15:12]);
    if (!w[16]) begin k = "R3"; return u + 10'd1; end
    if (sel == 0)  begin k = "R6"; return w[9:0]; end
    if (sel == 15) begin k = "R8"; return w[9:0] + 10'(op); end
    k = "R7";
    return fl[sel-1] ? w[9:0] : u + 10'd1;
  endfunction

  task automatic load(bit nano, int a, logic [67:0] d);
    @(negedge clk);
    chk("R1", "upc in reset", upc, 0);
    chk("R1", "ctrl in reset", ctrl, 0);
    ld_en = 1; ld_nano = nano; ld_addr = 10'(a); ld_data = d;
    if (nano) ns[a] = d; else us[a] = d[16:0];
    @(posedge clk);
    #1 ld_en = 0;
  endtask

  task automatic step();
    logic [16:0] w;
    logic [CW-1:0] e;
    logic [9:0] n;
    logic [67:0] nd;
    string k;
    bit wn = 0, wm = 0;
    w = us[m_upc];
    n = m_upc;
    e = (m_run && !w[16]) ? dcd(ns[w[8:0]]) : '0;
    chk(last, "upc", upc, m_upc);
    chk(!m_run ? "R2" : w[16] ? "R5" : (m_upc == 2 || m_upc == 20 || m_upc == 21) ? "R10" : "R4",
        "ctrl", ctrl, e);
    if (m_run && m_upc == 41) begin
      flags  = (pass % 15 == 14) ? 14'd0 : 14'(1 << (pass % 15));
      opcode = 4'(pass % 16);
      pass++;
    end
    if (m_run && pass == 5 && m_upc == 2 && !pn) begin
      pn = 1; wn = 1; nd = npat(5, 9);
      ld_en = 1; ld_nano = 1; ld_addr = 10'd5; ld_data = nd;
      #1 chk("R9", "nano write same-cycle ctrl", ctrl, e);
    end
    if (m_run && pass == 8 && m_upc == 8 && !pm) begin
      pm = 1; wm = 1;
      ld_en = 1; ld_nano = 0; ld_addr = 10'd8; ld_data = 68'(ujmp(0, 22));
    end
    if (m_run) begin
      n = nxt(w, m_upc, flags, opcode, k);
      last = wm ? "R9" : k;
    end else begin
      if (!start) flags = 14'(pass * 5 + 3);
      last = "R2";
    end
    @(posedge clk);
    if (wn) ns[5] = nd;
    if (wm) us[8] = ujmp(0, 22);
    m_upc = n;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic go();
    @(negedge clk);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    m_run = 1;
    last = "R2";
  endtask

  initial begin
    for (int a = 0; a < 512; a++) load(1, a, npat(a, 0));
    for (int a = 0; a < 8; a++) load(0, a, 68'(unano((a == 2) ? 5 : (a * 37) % 512)));
    for (int a = 1016; a < 1024; a++) load(0, a, 68'(unano((a * 37) % 512)));
    load(0, 8, 68'(ujmp(0, 20)));
    for (int a = 20; a < 24; a++) load(0, a, 68'(unano((a < 22) ? 5 : a * 37 % 512)));
    for (int a = 24; a < 38; a++) load(0, a, 68'(ujmp(a - 23, 40)));
    load(0, 38, 68'(unano(300)));
    load(0, 39, 68'(ujmp(0, 40)));
    load(0, 40, 68'(unano(411)));
    load(0, 41, 68'(ujmp(15, 1016)));
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    last = "R1";
    for (int i = 0; i < 4; i++) step();
    go();
    while (pass < 30) step();
    rst = 1;
    #1 chk("R1", "ctrl during mid-run reset", ctrl, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R1", "upc after reset", upc, 0);
    chk("R1", "ctrl after reset", ctrl, 0);
    rst = 0; m_upc = 0; m_run = 0; last = "R1";
    @(negedge clk);
    for (int i = 0; i < 4; i++) step();
    go();
    while (pass < 46) step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule